// File: doc/BRIEF.md
# Serial Bus Control and Status Register

This block is the eight-bit control and status register of a two-wire serial bus controller that has a signalling mode. It has three trigger bits. Two of them act once on the serial output latch, so that software can put a bus-release level or a command level on the line. The third arms a single acknowledge that is timed to the serial clock. The register also holds three sticky detection flags, for bus release, command and acknowledge. Each flag has its own set and clear events.

The CPU side is a plain write strobe with write data, plus a read-data bus that always shows the current register image. The bus detector, the transfer engine and the address comparator sit outside the block. They deliver single-cycle strobes. The serial clock arrives as a level and is sampled in the system clock domain. The block drives the output latch level and the resulting line level, which is the latch level forced low while an acknowledge is active.

Top module: `sbus_ctl_reg`

## Requirements
- R1: After reset, read data is 8'h00, the output latch is 1 and the line is 1.
- R2: Bits 7 (busy enable) and 5 (ack enable) are stored on every write. Writes to bits 6, 3 and 2 have no effect on them.
- R3: A write with bit 0 set while enabled sets the output latch to 1 at the next clock. When bits 0 and 1 are both set, bit 0 wins.
- R4: A write with bit 1 set and bit 0 clear while enabled clears the output latch to 0 at the next clock.
- R5: Bits 1 and 0 always read 0. While the interface is disabled, trigger writes leave the output latch unchanged.
- R6: A write with bit 4 set makes bit 4 read 1 until an acknowledge starts. The acknowledge starts at the first serial clock falling edge that is sampled after the write. The line is then low for one full serial clock period, until the next sampled falling edge, and bit 4 reads 0 again once the acknowledge starts.
- R7: A transfer-start strobe clears a pending bit 4. Disabling the interface clears bit 4 and ends any active acknowledge.
- R8: Bit 2 (release detected) is set by a release strobe in signalling mode. It is cleared by transfer start, by an address mismatch while wake-up mode is on, or by disable.
- R9: Bit 3 (command detected) is set by a command strobe in signalling mode. It is cleared by transfer start, by a release strobe in signalling mode, or by disable.
- R10: Bit 6 (ack detected) is set by an acknowledge strobe in signalling mode. It is cleared by transfer start or by disable.
- R11: When a set event and a clear event reach a flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Interface enable |
| sig_mode_i | input | 1 | Signalling mode active |
| wakeup_i | input | 1 | Wake-up (address match) mode |
| wr_i | input | 1 | CPU write strobe |
| wdata_i | input | 8 | CPU write data |
| rdata_o | output | 8 | Register image |
| sck_i | input | 1 | Serial clock level |
| xfer_start_i | input | 1 | Transfer start strobe |
| rel_det_i | input | 1 | Bus-release detected strobe |
| cmd_det_i | input | 1 | Command detected strobe |
| ack_det_i | input | 1 | Acknowledge detected strobe |
| addr_miss_i | input | 1 | Address mismatch strobe |
| so_latch_o | output | 1 | Serial output latch level |
| line_o | output | 1 | Line level after acknowledge override |

## Verification
The hardest cases to reach are the coincidences. One is an acknowledge write that lands in the same cycle as a sampled serial clock fall. Another is a re-arm while an acknowledge is still active. A third is a flag whose set and clear strobes arrive together. Directed sequences place these events on chosen cycles. A long random phase then toggles the serial clock and fires sparse strobes, so that they collide freely while a behavioural model is compared against the design on every clock.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int unsigned RegW     = 8;
  localparam int unsigned BitRelT  = 0;
  localparam int unsigned BitCmdT  = 1;
  localparam int unsigned BitRelD  = 2;
  localparam int unsigned BitCmdD  = 3;
  localparam int unsigned BitAckT  = 4;
  localparam int unsigned BitAckE  = 5;
  localparam int unsigned BitAckD  = 6;
  localparam int unsigned BitBusyE = 7;
  localparam int unsigned NumFlags = 3;
endpackage

// File: rtl/sbus_flag.sv
module sbus_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  p_set_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  p_clr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> !flag_o);
endmodule

// File: rtl/sbus_trig.sv
module sbus_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic wr_i,
  input  logic rel_t_i,
  input  logic cmd_t_i,
  output logic so_o
);
  logic act;
  assign act = wr_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                so_o <= 1'b1;
    else if (act && rel_t_i)    so_o <= 1'b1;
    else if (act && cmd_t_i)    so_o <= 1'b0;
  end

  p_rel_trig_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && en_i && rel_t_i |=> so_o);
  p_cmd_trig_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && en_i && cmd_t_i && !rel_t_i |=> !so_o);
  p_dis_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(so_o));
endmodule

// File: rtl/sbus_ack.sv
module sbus_ack (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sck_i,
  input  logic arm_i,
  input  logic abort_i,
  output logic pend_o,
  output logic active_o
);
  logic sck_q, fall;
  assign fall = sck_q & ~sck_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b1;
    else         sck_q <= sck_i;
  end

  // pending ack is consumed by the falling edge that starts it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pend_o <= 1'b0;
    else if (!en_i)           pend_o <= 1'b0;
    else if (pend_o && fall)  pend_o <= 1'b0;
    else if (arm_i)           pend_o <= 1'b1;
    else if (abort_i)         pend_o <= 1'b0;
  end

  // each falling edge opens a new ack if one is pending, else closes it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     active_o <= 1'b0;
    else if (!en_i)  active_o <= 1'b0;
    else if (fall)   active_o <= pend_o;
  end

  p_ack_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && pend_o && fall |=> active_o && !pend_o);
  p_ack_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && active_o && !fall |=> active_o);
  p_dis_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pend_o && !active_o);
endmodule

// File: rtl/sbus_ctl_reg.sv
module sbus_ctl_reg
  import sbus_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            sig_mode_i,
  input  logic            wakeup_i,
  input  logic            wr_i,
  input  logic [RegW-1:0] wdata_i,
  output logic [RegW-1:0] rdata_o,
  input  logic            sck_i,
  input  logic            xfer_start_i,
  input  logic            rel_det_i,
  input  logic            cmd_det_i,
  input  logic            ack_det_i,
  input  logic            addr_miss_i,
  output logic            so_latch_o,
  output logic            line_o
);
  logic busy_en_q, ack_en_q;
  logic ack_pend, ack_active;
  logic [NumFlags-1:0] f_set, f_clr, f_q;
  localparam int unsigned FRel = 0, FCmd = 1, FAck = 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_en_q <= 1'b0;
      ack_en_q  <= 1'b0;
    end else if (wr_i) begin
      busy_en_q <= wdata_i[BitBusyE];
      ack_en_q  <= wdata_i[BitAckE];
    end
  end

  sbus_trig i_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .wr_i   (wr_i),
    .rel_t_i(wdata_i[BitRelT]),
    .cmd_t_i(wdata_i[BitCmdT]),
    .so_o   (so_latch_o)
  );

  sbus_ack i_ack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .sck_i   (sck_i),
    .arm_i   (wr_i & wdata_i[BitAckT]),
    .abort_i (xfer_start_i),
    .pend_o  (ack_pend),
    .active_o(ack_active)
  );

  always_comb begin
    f_set[FRel] = sig_mode_i & rel_det_i;
    f_clr[FRel] = xfer_start_i | (wakeup_i & addr_miss_i) | ~en_i;
    f_set[FCmd] = sig_mode_i & cmd_det_i;
    f_clr[FCmd] = xfer_start_i | (sig_mode_i & rel_det_i) | ~en_i;
    f_set[FAck] = sig_mode_i & ack_det_i;
    f_clr[FAck] = xfer_start_i | ~en_i;
  end

  for (genvar g = 0; g < NumFlags; g++) begin : g_flag
    sbus_flag i_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (f_set[g]),
      .clr_i (f_clr[g]),
      .flag_o(f_q[g])
    );
  end

  always_comb begin
    rdata_o           = '0;
    rdata_o[BitBusyE] = busy_en_q;
    rdata_o[BitAckE]  = ack_en_q;
    rdata_o[BitAckT]  = ack_pend;
    rdata_o[BitAckD]  = f_q[FAck];
    rdata_o[BitCmdD]  = f_q[FCmd];
    rdata_o[BitRelD]  = f_q[FRel];
  end

  assign line_o = so_latch_o & ~ack_active;

  p_wr_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> rdata_o[BitBusyE] == $past(wdata_i[BitBusyE]));
  p_cmd_rel_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_mode_i && rel_det_i && !cmd_det_i |=> !rdata_o[BitCmdD]);
endmodule

// File: tb/test_sbus_ctl_reg.sv
`timescale 1ns/1ps
module test_sbus_ctl_reg;
  logic clk = 0, rst_n = 0;
  logic en = 0, sig = 0, wake = 0, wr = 0, sck = 1, xs = 0;
  logic reld = 0, cmdd = 0, ackd = 0, miss = 0;
  logic [7:0] wdata = 0, rdata;
  logic so, line;
  int checks = 0, errors = 0;
  bit cmp_on = 0;

  always #2.5 clk = ~clk;

  sbus_ctl_reg i_sbus_ctl_reg (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sig_mode_i(sig), .wakeup_i(wake),
    .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .sck_i(sck), .xfer_start_i(xs),
    .rel_det_i(reld), .cmd_det_i(cmdd), .ack_det_i(ackd), .addr_miss_i(miss),
    .so_latch_o(so), .line_o(line)
  );

  // behavioural reference model
  bit m_busy, m_acke, m_pend, m_act, m_so, m_rel, m_cmd, m_ackd, m_sck;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_acke = 0; m_pend = 0; m_act = 0; m_so = 1;
      m_rel = 0; m_cmd = 0; m_ackd = 0; m_sck = 1;
    end else begin
      bit edge_f, np, na;
      edge_f = m_sck && !sck;
      if (wr) begin m_busy = wdata[7]; m_acke = wdata[5]; end
      if (wr && en) begin
        if (wdata[0]) m_so = 1;
        else if (wdata[1]) m_so = 0;
      end
      np = m_pend; na = m_act;
      if (!en) begin np = 0; na = 0; end
      else begin
        if (edge_f) na = m_pend;
        if (m_pend && edge_f) np = 0;
        else if (wr && wdata[4]) np = 1;
        else if (xs) np = 0;
      end
      m_pend = np; m_act = na;
      m_rel = (sig && reld) ? 1 : (xs || (wake && miss) || !en) ? 0 : m_rel;
      m_cmd = (sig && cmdd) ? 1 : (xs || (sig && reld) || !en) ? 0 : m_cmd;
      m_ackd = (sig && ackd) ? 1 : (xs || !en) ? 0 : m_ackd;
      m_sck = sck;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R2 bit7", rdata[7], m_busy);
    chk("R2 bit5", rdata[5], m_acke);
    chk("R5 bits1:0", rdata[1:0], 0);
    chk("R6 bit4", rdata[4], m_pend);
    chk("R8 bit2", rdata[2], m_rel);
    chk("R9 bit3", rdata[3], m_cmd);
    chk("R10 bit6", rdata[6], m_ackd);
    chk("R3 latch", so, m_so);
    chk("R6 line", line, m_so && !m_act);
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(logic [7:0] d);
    wr = 1; wdata = d; cyc(); wr = 0; wdata = 0;
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_sim();
  end

  initial begin
    cyc(3);
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 latch", so, 1);
    chk("R1 line", line, 1);
    rst_n = 1; en = 1; sig = 1;
    cmp_on = 1;
    cyc(2);
    // R2 R3: all ones, release wins over command
    write(8'hFF); chk("R3 both", so, 1); chk("R2 ro", rdata[6] | rdata[3] | rdata[2], 0);
    en = 0; cyc(); en = 1;
    write(8'h02); chk("R4 cmd", so, 0);
    write(8'h01); chk("R3 rel", so, 1);
    en = 0; write(8'h02); chk("R5 disabled", so, 1); en = 1; cyc();
    // R6 ack timing
    sck = 1; cyc(2);
    write(8'h10); chk("R6 pending", rdata[4], 1);
    sck = 0; cyc(); chk("R6 start", line, 0); chk("R6 cleared", rdata[4], 0);
    cyc(); sck = 1; cyc(2); chk("R6 hold", line, 0);
    sck = 0; cyc(); chk("R6 end", line, 1);
    sck = 1; cyc();
    // ack write in same cycle as a sampled fall
    wr = 1; wdata = 8'h10; sck = 0; cyc(); wr = 0; wdata = 0;
    chk("R6 same-cycle", line, 1); chk("R6 still pending", rdata[4], 1);
    sck = 1; cyc(); sck = 0; cyc(); chk("R6 late start", line, 0);
    write(8'h10); sck = 1; cyc(); sck = 0; cyc(); chk("R6 back-to-back", line, 0);
    sck = 1; cyc(); sck = 0; cyc(); chk("R6 release", line, 1); sck = 1;
    // R7
    write(8'h10); xs = 1; cyc(); xs = 0; chk("R7 xfer", rdata[4], 0);
    write(8'h10); sck = 0; cyc(); sck = 1;
    en = 0; cyc(); en = 1; chk("R7 disable", line, 1); cyc();
    // R8 R9 R10 R11
    reld = 1; cyc(); reld = 0; chk("R8 set", rdata[2], 1);
    wake = 1; miss = 1; cyc(); miss = 0; wake = 0; chk("R8 miss", rdata[2], 0);
    cmdd = 1; cyc(); cmdd = 0; chk("R9 set", rdata[3], 1);
    reld = 1; cyc(); reld = 0; chk("R9 rel clr", rdata[3], 0);
    ackd = 1; cyc(); ackd = 0; chk("R10 set", rdata[6], 1);
    sig = 0; cmdd = 1; cyc(); cmdd = 0; sig = 1; chk("R9 no sig", rdata[3], 0);
    reld = 1; cmdd = 1; xs = 1; ackd = 1; cyc(); reld = 0; cmdd = 0; xs = 0; ackd = 0;
    chk("R11 rel", rdata[2], 1); chk("R11 cmd", rdata[3], 1); chk("R11 ackd", rdata[6], 1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(2) == 0) sck = ~sck;
      wr = ($urandom_range(7) == 0); wdata = 8'($urandom);
      xs = ($urandom_range(19) == 0);
      reld = ($urandom_range(9) == 0); cmdd = ($urandom_range(9) == 0);
      ackd = ($urandom_range(9) == 0); miss = ($urandom_range(9) == 0);
      wake = ($urandom_range(1) == 0);
      if ($urandom_range(29) == 0) en = ~en;
      if ($urandom_range(49) == 0) sig = ~sig;
      cyc();
    end
    wr = 0; xs = 0; reld = 0; cmdd = 0; ackd = 0; miss = 0;
    cyc(2);
    finish_sim();
  end
endmodule